// File: doc/BRIEF.md
# I2C Host Command Sequencer

This block is the command layer of an I2C host controller. It sits between a CPU-facing register port and a bit-level bus engine. The CPU writes a small control register, which holds a flush strobe, a stored acknowledge choice and a two-bit command strobe. The CPU also raises address-write, data-write and data-read strobes. From these inputs the block tracks a host state and passes one request at a time to the bus engine. A request is a start with address, a repeated start, a byte read, a byte write or a stop. Each request carries a flag that says whether the engine must first send the stored ACK/NACK.

SCL/SDA timing, arbitration and clock stretching belong to the engine. They reach this block only through `bus_free`, `req_ready` and `eng_done`. The request port is valid/ready. Once `req_valid` is high, the block holds it and every request field steady until it samples `req_ready` high. The engine then signals completion with a one-cycle `eng_done`. No new request is formed before that. Smart mode (`smart_en`) lets a CPU read of the data register trigger the acknowledge-and-read-next step without a command write.

Top module: `i2c_host_cmd_seq`

## Requirements
- R1: `ctl_rdata` returns the stored acknowledge choice at bit 2. Bits 3, 1 and 0 always read 0.
- R2: After reset, `host_state` is 0 (idle), `req_valid` is 0, `cmd_err` is 0 and `ctl_rdata` is 0. The state codes are 0 idle, 1 owner, 2 waiting for data and 3 busy.
- R3: In idle, a pending address is issued as a start request. The op code is 0 and `req_byte` is the address. `req_valid` rises on the second clock edge after the address write, provided `bus_free` is high. Otherwise it rises on the first edge at which `bus_free` is high. `dir_read` equals address bit 0, where 1 means read.
- R4: Command 1 (control bits 1:0 = 1) in the owner or waiting state issues a repeated start. The op code is 1, `req_byte` is the last address and `req_ack_en` equals `dir_read`.
- R5: Command 3 issues a stop (op code 4) with `req_ack_en` equal to `dir_read`. After `eng_done` the state is idle.
- R6: Command 2 in read direction issues a read (op code 2) with `req_ack_en` = 1. After `eng_done` the state is owner.
- R7: Command 2 in write direction issues no request and moves to the waiting state. A pending data byte is then sent as a write (op code 3) with `req_ack_en` = 0 and `req_byte` equal to that data. After `eng_done` the state is owner.
- R8: `req_ack_val` is the acknowledge choice (0 ACK, 1 NACK). A choice written in the same control write as a command applies to that command.
- R9: With `smart_en` high, a data read in the owner state with `dir_read` high issues a read with `req_ack_en` = 1. A data read with `smart_en` low issues nothing. A data write never issues a read or an acknowledge.
- R10: Command 0 causes no request and no state change.
- R11: A request's `req_valid`, `req_op` and `req_byte` stay steady until `req_ready` is sampled high. The state reads busy (3) from issue until `eng_done`.
- R12: A non-zero command that arrives while busy is ignored and sets `cmd_err`. The flag stays set until a flush.
- R13: A control write with bit 3 set returns the state to idle on the next edge. It also drops `req_valid`, clears `cmd_err` and discards pending address and data. A control write with bit 3 clear does none of this.
- R14: After a flush, an address write (bit 0 = 0) followed by a data write gives a start request and then, once the start completes, a write of that data byte. No command write is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smart_en | input | 1 | Auto-acknowledge on data read |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write data: [3] flush, [2] ack choice, [1:0] command |
| ctl_rdata | output | 4 | Control register read value |
| addr_wr | input | 1 | Address register write strobe |
| addr_wdata | input | 8 | Address byte, bit 0 = direction |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Data byte to send |
| data_rd | input | 1 | Data register read strobe |
| bus_free | input | 1 | Bus engine sees the bus idle |
| req_valid | output | 1 | Request to engine valid |
| req_ready | input | 1 | Engine accepts request |
| req_op | output | 3 | 0 start, 1 repeated start, 2 read, 3 write, 4 stop |
| req_ack_en | output | 1 | Send ACK/NACK before the operation |
| req_ack_val | output | 1 | 0 ACK, 1 NACK |
| req_byte | output | 8 | Address or data byte |
| eng_done | input | 1 | One-cycle completion from engine |
| host_state | output | 2 | 0 idle, 1 owner, 2 waiting data, 3 busy |
| dir_read | output | 1 | Latched transfer direction |
| cmd_err | output | 1 | Sticky command-while-busy flag |

## Verification
Every result of this block is registered once after the strobe that causes it. A command, flush or smart-mode read shows up on the request port and state one edge after the strobe. An address needs two edges, one to record it and one to issue the start. A data write in the waiting state also needs two edges. State after completion is valid one edge after `eng_done`. The bench drives every input at the falling edge and reads results at the following falling edge, after exactly the number of rising edges listed. For the bus-free gate and the back-pressure case it also samples the cycles before the result is due, to confirm nothing happened early.

// File: rtl/i2c_hcs_pkg.sv
package i2c_hcs_pkg;
  localparam int CTL_W     = 4;
  localparam int CTL_FLUSH = 3;
  localparam int CTL_ACK   = 2;
  localparam int CMD_W     = 2;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_OWNER = 2'd1,
    HS_WAIT  = 2'd2,
    HS_BUSY  = 2'd3
  } hstate_t;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_READ   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_STOP   = 3'd4
  } op_t;

  localparam logic [CMD_W-1:0] CMD_NONE   = 2'd0;
  localparam logic [CMD_W-1:0] CMD_RSTART = 2'd1;
  localparam logic [CMD_W-1:0] CMD_XFER   = 2'd2;
  localparam logic [CMD_W-1:0] CMD_STOP   = 2'd3;
endpackage

// File: rtl/i2c_hcs_ctrl_reg.sv
module i2c_hcs_ctrl_reg
  import i2c_hcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             flush,
  output logic             cmd_vld,
  output logic [CMD_W-1:0] cmd,
  output logic             ack_now,
  output logic             ack_reg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ack_reg <= 1'b0;
    else if (ctl_wr) ack_reg <= ctl_wdata[CTL_ACK];
  end

  // Strobes live for the write cycle only; command/flush never stored.
  assign flush   = ctl_wr && ctl_wdata[CTL_FLUSH];
  assign cmd     = ctl_wdata[CMD_W-1:0];
  assign cmd_vld = ctl_wr && (cmd != CMD_NONE);
  assign ack_now = ctl_wr ? ctl_wdata[CTL_ACK] : ack_reg;

  always_comb begin
    ctl_rdata          = '0;
    ctl_rdata[CTL_ACK] = ack_reg;
  end
endmodule

// File: rtl/i2c_hcs_latch.sv
module i2c_hcs_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          consume,
  output logic [DW-1:0] value,
  output logic          pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      pend  <= 1'b0;
    end else if (flush) begin
      pend  <= 1'b0;
    end else if (wr) begin
      value <= wdata;
      pend  <= 1'b1;
    end else if (consume) begin
      pend  <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_hcs_fsm.sv
module i2c_hcs_fsm
  import i2c_hcs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             cmd_vld,
  input  logic [CMD_W-1:0] cmd,
  input  logic             ack_now,
  input  logic             smart_en,
  input  logic             data_rd,
  input  logic             bus_free,
  input  logic [DW-1:0]    addr,
  input  logic             addr_pend,
  input  logic [DW-1:0]    data,
  input  logic             data_pend,
  output logic             consume_addr,
  output logic             consume_data,
  output logic             req_valid,
  input  logic             req_ready,
  output op_t              req_op,
  output logic             req_ack_en,
  output logic             req_ack_val,
  output logic [DW-1:0]    req_byte,
  input  logic             eng_done,
  output hstate_t          state,
  output logic             cmd_err
);
  hstate_t ret_q, ret_d;
  logic    issue, goto_wait;
  op_t     op_d;
  logic    ack_en_d;
  logic [DW-1:0] byte_d;
  logic    dir;

  assign dir = addr[0];

  always_comb begin
    issue        = 1'b0;
    goto_wait    = 1'b0;
    op_d         = OP_START;
    ack_en_d     = 1'b0;
    byte_d       = addr;
    ret_d        = HS_OWNER;
    consume_addr = 1'b0;
    consume_data = 1'b0;
    unique case (state)
      HS_IDLE: begin
        if (addr_pend && bus_free) begin
          issue        = 1'b1;
          consume_addr = 1'b1;
          ret_d        = dir ? HS_OWNER : HS_WAIT;
        end
      end
      HS_OWNER, HS_WAIT: begin
        if (cmd_vld) begin
          unique case (cmd)
            CMD_RSTART: begin
              issue    = 1'b1;
              op_d     = OP_RSTART;
              ack_en_d = dir;
              ret_d    = dir ? HS_OWNER : HS_WAIT;
            end
            CMD_STOP: begin
              issue    = 1'b1;
              op_d     = OP_STOP;
              ack_en_d = dir;
              ret_d    = HS_IDLE;
            end
            default: begin
              if (dir) begin
                issue    = 1'b1;
                op_d     = OP_READ;
                ack_en_d = 1'b1;
              end else begin
                goto_wait = 1'b1;
              end
            end
          endcase
        end else if (state == HS_OWNER && smart_en && dir && data_rd) begin
          issue    = 1'b1;
          op_d     = OP_READ;
          ack_en_d = 1'b1;
        end else if (state == HS_WAIT && data_pend) begin
          issue        = 1'b1;
          op_d         = OP_WRITE;
          byte_d       = data;
          consume_data = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= HS_IDLE;
      ret_q       <= HS_IDLE;
      req_valid   <= 1'b0;
      req_op      <= OP_START;
      req_ack_en  <= 1'b0;
      req_ack_val <= 1'b0;
      req_byte    <= '0;
      cmd_err     <= 1'b0;
    end else if (flush) begin
      state     <= HS_IDLE;
      req_valid <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      if (cmd_vld && state == HS_BUSY) cmd_err <= 1'b1;
      if (issue) begin
        state       <= HS_BUSY;
        ret_q       <= ret_d;
        req_valid   <= 1'b1;
        req_op      <= op_d;
        req_ack_en  <= ack_en_d;
        req_ack_val <= ack_now;
        req_byte    <= byte_d;
      end else if (goto_wait) begin
        state <= HS_WAIT;
      end else if (state == HS_BUSY) begin
        if (req_valid) begin
          if (req_ready) req_valid <= 1'b0;
        end else if (eng_done) begin
          state <= ret_q;
        end
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !flush) |=> (req_valid && $stable(req_op) && $stable(req_byte)));
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (state == HS_BUSY));
  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err && !flush) |=> cmd_err);
  p_flush_r13: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (state == HS_IDLE && !req_valid && !cmd_err));
  p_write_noack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_WRITE) |-> !req_ack_en);
  p_read_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_READ) |-> req_ack_en);
endmodule

// File: rtl/i2c_host_cmd_seq.sv
module i2c_host_cmd_seq
  import i2c_hcs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smart_en,
  input  logic          ctl_wr,
  input  logic [3:0]    ctl_wdata,
  output logic [3:0]    ctl_rdata,
  input  logic          addr_wr,
  input  logic [DW-1:0] addr_wdata,
  input  logic          data_wr,
  input  logic [DW-1:0] data_wdata,
  input  logic          data_rd,
  input  logic          bus_free,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [2:0]    req_op,
  output logic          req_ack_en,
  output logic          req_ack_val,
  output logic [DW-1:0] req_byte,
  input  logic          eng_done,
  output logic [1:0]    host_state,
  output logic          dir_read,
  output logic          cmd_err
);
  logic             flush, cmd_vld, ack_now, ack_reg;
  logic [CMD_W-1:0] cmd;
  logic [DW-1:0]    addr_q, data_q;
  logic             addr_pend, data_pend, consume_addr, consume_data;
  op_t              op_q;
  hstate_t          st_q;

  i2c_hcs_ctrl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .flush(flush), .cmd_vld(cmd_vld), .cmd(cmd),
    .ack_now(ack_now), .ack_reg(ack_reg)
  );

  i2c_hcs_latch #(.DW(DW)) u_addr (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr(addr_wr),
    .wdata(addr_wdata), .consume(consume_addr), .value(addr_q), .pend(addr_pend)
  );

  i2c_hcs_latch #(.DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr(data_wr),
    .wdata(data_wdata), .consume(consume_data), .value(data_q), .pend(data_pend)
  );

  i2c_hcs_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cmd_vld(cmd_vld), .cmd(cmd),
    .ack_now(ack_now), .smart_en(smart_en), .data_rd(data_rd),
    .bus_free(bus_free), .addr(addr_q), .addr_pend(addr_pend),
    .data(data_q), .data_pend(data_pend), .consume_addr(consume_addr),
    .consume_data(consume_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(op_q), .req_ack_en(req_ack_en), .req_ack_val(req_ack_val),
    .req_byte(req_byte), .eng_done(eng_done), .state(st_q), .cmd_err(cmd_err)
  );

  assign req_op     = op_q;
  assign host_state = st_q;
  assign dir_read   = addr_q[0];

  p_rd_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_rdata[2] == $past(ctl_wdata[2])));
  p_noop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata == 4'b0000 && host_state == 2'd1 && !data_rd && !data_wr)
      |=> (host_state == 2'd1 && !req_valid));
endmodule

// File: tb/sim_i2c_host_cmd_seq.sv
module sim_i2c_host_cmd_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smart_en = 1'b0, ctl_wr = 1'b0, addr_wr = 1'b0, data_wr = 1'b0;
  logic       data_rd = 1'b0, bus_free = 1'b1, req_ready = 1'b0, eng_done = 1'b0;
  logic [3:0] ctl_wdata = '0, ctl_rdata;
  logic [7:0] addr_wdata = '0, data_wdata = '0, req_byte;
  logic       req_valid, req_ack_en, req_ack_val, dir_read, cmd_err;
  logic [2:0] req_op;
  logic [1:0] host_state;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  i2c_host_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .smart_en(smart_en), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .addr_wr(addr_wr),
    .addr_wdata(addr_wdata), .data_wr(data_wr), .data_wdata(data_wdata),
    .data_rd(data_rd), .bus_free(bus_free), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_ack_en(req_ack_en),
    .req_ack_val(req_ack_val), .req_byte(req_byte), .eng_done(eng_done),
    .host_state(host_state), .dir_read(dir_read), .cmd_err(cmd_err)
  );

  // {dir, cmd[1:0], ack, exp_valid, exp_op[2:0], exp_ack_en, exp_ack_val, exp_state[1:0]}
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 2'd2, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0, 2'd3},
    {1'b1, 2'd2, 1'b1, 1'b1, 3'd2, 1'b1, 1'b1, 2'd3},
    {1'b1, 2'd1, 1'b1, 1'b1, 3'd1, 1'b1, 1'b1, 2'd3},
    {1'b0, 2'd1, 1'b1, 1'b1, 3'd1, 1'b0, 1'b1, 2'd3},
    {1'b1, 2'd3, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0, 2'd3},
    {1'b0, 2'd3, 1'b0, 1'b1, 3'd4, 1'b0, 1'b0, 2'd3},
    {1'b0, 2'd2, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 2'd2},
    {1'b1, 2'd0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 2'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic wr_ctl(input logic [3:0] d);
    ctl_wr = 1'b1; ctl_wdata = d; tick(); ctl_wr = 1'b0;
  endtask
  task automatic wr_addr(input logic [7:0] a);
    addr_wr = 1'b1; addr_wdata = a; tick(); addr_wr = 1'b0;
  endtask
  task automatic wr_data(input logic [7:0] d);
    data_wr = 1'b1; data_wdata = d; tick(); data_wr = 1'b0;
  endtask
  task automatic rd_data();
    data_rd = 1'b1; tick(); data_rd = 1'b0;
  endtask
  task automatic serve();
    req_ready = 1'b1; tick(); req_ready = 1'b0;
    eng_done = 1'b1; tick(); eng_done = 1'b0;
  endtask
  task automatic open_xfer(input logic dir);
    wr_addr({7'h2a, dir});
    tick();
    chk("R3 start valid", req_valid, 1);
    chk("R3 start op", req_op, 0);
    serve();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R2 reset state
    chk("R2 state", host_state, 0);
    chk("R2 req_valid", req_valid, 0);
    chk("R2 cmd_err", cmd_err, 0);
    chk("R2 rdata", ctl_rdata, 0);

    // Vector table: command path from an open transfer (R4 R5 R6 R7 R8 R10)
    for (int i = 0; i < NV; i++) begin
      wr_ctl(4'b1000);
      open_xfer(VEC[i][11]);
      wr_ctl({1'b0, VEC[i][8], VEC[i][10:9]});
      chk($sformatf("R4-vec%0d valid", i), req_valid, VEC[i][7]);
      chk($sformatf("R10 vec%0d state", i), host_state, VEC[i][1:0]);
      if (VEC[i][7]) begin
        chk($sformatf("R5 vec%0d op", i), req_op, VEC[i][6:4]);
        chk($sformatf("R6 vec%0d ack_en", i), req_ack_en, VEC[i][3]);
        chk($sformatf("R8 vec%0d ack_val", i), req_ack_val, VEC[i][2]);
      end
    end
    wr_ctl(4'b1000);

    // R1 readback: command field and flush read 0, ack bit readable
    wr_ctl(4'b0111);
    chk("R1 rdata ack", ctl_rdata, 4'b0100);
    chk("R10 idle cmd ignored", req_valid, 0);
    wr_ctl(4'b0000);
    chk("R1 rdata clear", ctl_rdata, 0);

    // R3 bus-free gate
    bus_free = 1'b0;
    wr_addr(8'hA1);
    tick(); tick();
    chk("R3 held off", req_valid, 0);
    chk("R3 idle", host_state, 0);
    bus_free = 1'b1;
    tick();
    chk("R3 issued", req_valid, 1);
    chk("R3 byte", req_byte, 8'hA1);
    chk("R3 dir", dir_read, 1);
    serve();
    chk("R3 owner after start", host_state, 1);

    // R11 back-pressure and R12 busy command
    wr_ctl(4'b0010);
    tick(); tick();
    chk("R11 held valid", req_valid, 1);
    chk("R11 held op", req_op, 2);
    chk("R11 busy", host_state, 3);
    wr_ctl(4'b0011);
    chk("R12 err set", cmd_err, 1);
    chk("R12 op unchanged", req_op, 2);
    serve();
    chk("R6 owner after read", host_state, 1);
    chk("R12 sticky", cmd_err, 1);

    // R9 smart mode
    smart_en = 1'b1;
    rd_data();
    chk("R9 smart read", req_valid, 1);
    chk("R9 smart op", req_op, 2);
    chk("R9 smart ack_en", req_ack_en, 1);
    serve();
    smart_en = 1'b0;
    rd_data();
    chk("R9 no smart", req_valid, 0);
    chk("R9 state", host_state, 1);

    // R5 stop to idle
    wr_ctl(4'b0111);
    chk("R5 stop op", req_op, 4);
    chk("R5 ack_val", req_ack_val, 1);
    serve();
    chk("R5 idle", host_state, 0);

    // R13 flush semantics
    chk("R13 err before flush", cmd_err, 1);
    wr_ctl(4'b1000);
    chk("R13 err cleared", cmd_err, 0);
    wr_addr(8'h55);
    tick();
    chk("R13 busy setup", req_valid, 1);
    wr_ctl(4'b0000);
    chk("R13 flush 0 no effect", req_valid, 1);
    wr_ctl(4'b1000);
    chk("R13 flush drop", req_valid, 0);
    chk("R13 flush idle", host_state, 0);

    // R14 / R7 write path
    wr_addr(8'h50);
    wr_data(8'h3C);
    chk("R14 start", req_valid, 1);
    chk("R14 start op", req_op, 0);
    serve();
    chk("R14 waiting", host_state, 2);
    tick();
    chk("R14 write op", req_op, 3);
    chk("R14 write byte", req_byte, 8'h3C);
    chk("R7 write no ack", req_ack_en, 0);
    serve();
    chk("R7 owner after write", host_state, 1);
    smart_en = 1'b1;
    wr_data(8'h11);
    chk("R9 data write no trigger", req_valid, 0);
    chk("R9 data write state", host_state, 1);
    smart_en = 1'b0;
    wr_ctl(4'b0010);
    chk("R7 wait state", host_state, 2);
    tick();
    chk("R7 write issued", req_valid, 1);
    chk("R7 write data", req_byte, 8'h11);
    serve();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule